// File: doc/BRIEF.md
# Per-Instruction Stride Prefetch Engine

This block watches the stream of demand loads reaching a cache and learns, for each load instruction, whether that instruction walks memory with a fixed step. It keeps a direct-mapped table. The table is indexed by the instruction address after the two always-zero low bits are removed. Each entry holds a tag, the previous line address seen for that instruction, a stride and a two-bit confidence state. On every load the block looks up the entry and updates it. If the entry is confident enough, the block proposes the line one stride ahead as a prefetch.

The candidate line is shown combinationally on `probe_line` in the same cycle as the access. The surrounding cache answers on `probe_present` whether it already holds that line. If it does, no request is made. Otherwise the request is registered and offered on a valid/ready output one cycle later. A request that has not been taken is replaced by any newer one. Store accesses, the cache, and the handling of requests on the memory side all belong to other blocks.

Top module: `stride_pf_top`

## Requirements
- R1: A load whose PC tag (PC bits above index and the two dropped bits) differs from the stored tag allocates the entry: tag written, last line set to the access line, stride zero, state initial. No prefetch is issued for that access. At reset every tag is zero, which marks the entry empty.
- R2: On a tag hit the observed stride is the access line minus the stored last line. If it differs from the stored stride in the initial state, the entry moves to transient and takes the observed stride.
- R3: On a hit whose observed stride equals the stored stride, the next state follows a fixed rule and the stored stride is kept. Initial, transient and steady go to steady. No-prediction goes to transient.
- R4: In the steady state, a differing stride sends the entry to initial and keeps the old stride, so the prefetch still uses the old stride.
- R5: In the transient state a differing stride moves the entry to no-prediction. In the no-prediction state a differing stride keeps it there. In both cases the observed stride is stored, and an entry in no-prediction never issues a prefetch.
- R6: Every hit overwrites the last-line field with the access line, whatever the transition.
- R7: No prefetch is issued when the stride after the update is zero.
- R8: During an access, `probe_line` equals the access line plus the updated stride in the same cycle. If `probe_present` is high in that cycle, the prefetch is suppressed.
- R9: An issued prefetch appears on `pf_valid`/`pf_line` one clock after the access. It is held unchanged until `pf_ready` is high, and a newer prefetch replaces one that is still pending.
- R10: After reset `pf_valid` is low. A cycle without an access issues nothing and leaves the table unchanged.
- R11: Two PCs that share an index but differ in tag evict each other. PCs with different indexes train independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | A demand load is presented this cycle |
| acc_pc | input | PC_W | Instruction address of the load |
| acc_line | input | LINE_W | Line-granular address of the load |
| probe_line | output | LINE_W | Candidate prefetch line for the current access (combinational) |
| probe_present | input | 1 | Cache already holds `probe_line` |
| pf_valid | output | 1 | Prefetch request pending |
| pf_ready | input | 1 | Consumer takes the pending request |
| pf_line | output | LINE_W | Line to prefetch |

## Verification
`probe_line` is a same-cycle result. The bench therefore reads it 1 ns after driving an access, before the clock edge, and only then sets `probe_present`, as the cache would. The table update and the prefetch register take effect at the edge that accepts the access. The bench's reference model advances at that same edge, and `pf_valid`/`pf_line` are compared at the following falling edge, one cycle after the access. Held and replaced requests are checked the same way, because the model applies the `pf_ready` value that was driven for each cycle.

// File: rtl/stride_pf_pkg.sv
`timescale 1ns/1ps
package stride_pf_pkg;
    // Confidence of one table entry
    typedef enum logic [1:0] {
        RS_INIT   = 2'd0,
        RS_TRANS  = 2'd1,
        RS_STEADY = 2'd2,
        RS_NOPRED = 2'd3
    } reg_state_e;
endpackage

// File: rtl/stride_table.sv
`timescale 1ns/1ps
module stride_table
    import stride_pf_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 24,
    parameter int LINE_W  = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_last,
    output logic [LINE_W-1:0] rd_stride,
    output reg_state_e        rd_state,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_last,
    input  logic [LINE_W-1:0] wr_stride,
    input  reg_state_e        wr_state
);
    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [LINE_W-1:0] last;
        logic [LINE_W-1:0] stride;
        reg_state_e        st;
    } ent_t;

    ent_t ent_arr [ENTRIES];
    ent_t wr_ent;

    assign wr_ent = '{tag: wr_tag, last: wr_last, stride: wr_stride, st: wr_state};

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        ent_t ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                ent_d = wr_ent;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign ent_arr[i] = ent_q;
    end

    assign rd_tag    = ent_arr[rd_idx].tag;
    assign rd_last   = ent_arr[rd_idx].last;
    assign rd_stride = ent_arr[rd_idx].stride;
    assign rd_state  = ent_arr[rd_idx].st;

    // R6: the written last-line value is what the entry holds afterwards
    a_r6_last_written: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ent_arr[$past(wr_idx)].last == $past(wr_last)));
endmodule

// File: rtl/stride_update.sv
`timescale 1ns/1ps
module stride_update
    import stride_pf_pkg::*;
#(
    parameter int LINE_W = 32
) (
    input  logic              hit,
    input  logic [LINE_W-1:0] line,
    input  logic [LINE_W-1:0] last,
    input  logic [LINE_W-1:0] stride,
    input  reg_state_e        state,
    output reg_state_e        nx_state,
    output logic [LINE_W-1:0] nx_stride,
    output logic              cand,
    output logic [LINE_W-1:0] target
);
    logic [LINE_W-1:0] obs;
    logic              same;

    always_comb begin
        obs       = line - last;
        same      = (obs == stride);
        nx_state  = state;
        nx_stride = stride;
        if (!hit) begin
            nx_state  = RS_INIT;
            nx_stride = '0;
        end else begin
            unique case (state)
                RS_INIT: begin
                    if (same) nx_state = RS_STEADY;
                    else begin
                        nx_state  = RS_TRANS;
                        nx_stride = obs;
                    end
                end
                RS_TRANS: begin
                    if (same) nx_state = RS_STEADY;
                    else begin
                        nx_state  = RS_NOPRED;
                        nx_stride = obs;
                    end
                end
                RS_STEADY: begin
                    nx_state = same ? RS_STEADY : RS_INIT;
                end
                RS_NOPRED: begin
                    if (same) nx_state = RS_TRANS;
                    else      nx_stride = obs;
                end
                default: nx_state = RS_INIT;
            endcase
        end
        cand   = (nx_state != RS_NOPRED) && (nx_stride != '0);
        target = line + nx_stride;
    end
endmodule

// File: rtl/stride_pf_top.sv
`timescale 1ns/1ps
module stride_pf_top
    import stride_pf_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int LINE_W  = 32,
    parameter int ENTRIES = 64,
    parameter int PC_LSB  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [PC_W-1:0]   acc_pc,
    input  logic [LINE_W-1:0] acc_line,
    output logic [LINE_W-1:0] probe_line,
    input  logic              probe_present,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [LINE_W-1:0] pf_line
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = PC_W - IDX_W - PC_LSB;

    typedef struct packed {
        logic              vld;
        logic [LINE_W-1:0] line;
    } out_t;

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic [TAG_W-1:0]  rd_tag;
    logic [LINE_W-1:0] rd_last, rd_stride, nx_stride, target;
    reg_state_e        rd_state, nx_state;
    logic              hit, cand, issue;
    logic              unused_pc_bits;
    out_t              out_d, out_q;

    assign idx            = acc_pc[IDX_W+PC_LSB-1:PC_LSB];
    assign tag            = acc_pc[PC_W-1:IDX_W+PC_LSB];
    assign unused_pc_bits = ^acc_pc[PC_LSB-1:0];
    assign hit            = (rd_tag == tag);

    stride_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (idx),
        .rd_tag    (rd_tag),
        .rd_last   (rd_last),
        .rd_stride (rd_stride),
        .rd_state  (rd_state),
        .wr_en     (acc_valid),
        .wr_idx    (idx),
        .wr_tag    (tag),
        .wr_last   (acc_line),
        .wr_stride (nx_stride),
        .wr_state  (nx_state)
    );

    stride_update #(.LINE_W(LINE_W)) u_update (
        .hit       (hit),
        .line      (acc_line),
        .last      (rd_last),
        .stride    (rd_stride),
        .state     (rd_state),
        .nx_state  (nx_state),
        .nx_stride (nx_stride),
        .cand      (cand),
        .target    (target)
    );

    assign probe_line = target;
    assign issue      = acc_valid && cand && !probe_present;

    always_comb begin
        out_d = out_q;
        if (issue) begin
            out_d.vld  = 1'b1;
            out_d.line = target;
        end else if (pf_ready) begin
            out_d.vld  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign pf_valid = out_q.vld;
    assign pf_line  = out_q.line;

    // R1: an allocation never proposes a prefetch
    a_r1_alloc_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !hit) |-> !issue);
    // R5: no-prediction entries stay silent
    a_r5_nopred_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && nx_state == RS_NOPRED) |-> !issue);
    // R7: a prefetch never targets the accessed line itself
    a_r7_nonzero_step: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (probe_line != acc_line));
    // R9: request appears one cycle later with the probed line
    a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> (pf_valid && pf_line == $past(probe_line)));
    // R9: a stalled request is held unchanged
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready && !issue) |=> (pf_valid && $stable(pf_line)));
    // R10: no access plus a taken request leaves nothing pending
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && pf_ready) |=> !pf_valid);
endmodule

// File: tb/sim_stride_pf_top.sv
`timescale 1ns/1ps
module sim_stride_pf_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_pc = '0;
    logic [31:0] acc_line = '0;
    logic [31:0] probe_line;
    logic        probe_present = 1'b0;
    logic        pf_valid;
    logic        pf_ready = 1'b1;
    logic [31:0] pf_line;

    always #2.5 clk = ~clk;

    stride_pf_top u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_pc(acc_pc),
        .acc_line(acc_line), .probe_line(probe_line), .probe_present(probe_present),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_line(pf_line)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model: states 0 initial, 1 transient, 2 steady, 3 no-prediction
    logic [23:0] m_tag    [64];
    logic [31:0] m_last   [64];
    logic [31:0] m_stride [64];
    int          m_st     [64];
    logic        mv = 1'b0;
    logic [31:0] ml = '0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic void model_next(int st, logic [31:0] str, logic [31:0] obs, bit h,
                                       output int nst, output logic [31:0] nstr);
        bit same = (obs == str);
        nst = st; nstr = str;
        if (!h) begin nst = 0; nstr = '0; end
        else if (st == 0) begin if (same) nst = 2; else begin nst = 1; nstr = obs; end end
        else if (st == 1) begin if (same) nst = 2; else begin nst = 3; nstr = obs; end end
        else if (st == 2) begin nst = same ? 2 : 0; end
        else begin if (same) nst = 1; else nstr = obs; end
    endfunction

    task automatic step(string req, bit v, logic [31:0] pc, logic [31:0] line, bit pres, bit rdy);
        int          idx, nst;
        logic [31:0] nstr;
        bit          h, cand, iss;
        @(negedge clk);
        chk(req, "pf_valid", {31'd0, pf_valid}, {31'd0, mv});
        if (mv) chk(req, "pf_line", pf_line, ml);
        acc_valid = v; acc_pc = pc; acc_line = line; pf_ready = rdy;
        idx = int'(pc[7:2]);
        h = (m_tag[idx] == pc[31:8]);
        model_next(m_st[idx], m_stride[idx], line - m_last[idx], h, nst, nstr);
        cand = (nst != 3) && (nstr != 0);
        #1;
        if (v && cand) chk(req, "probe_line", probe_line, line + nstr);
        probe_present = pres;
        @(posedge clk);
        iss = v && cand && !pres;
        if (v) begin
            m_tag[idx] = pc[31:8]; m_last[idx] = line;
            m_stride[idx] = nstr; m_st[idx] = nst;
        end
        if (iss) begin mv = 1'b1; ml = line + nstr; end
        else if (rdy) mv = 1'b0;
    endtask

    localparam logic [31:0] PA = 32'h0040_0010;
    localparam logic [31:0] PB = 32'h0040_0024;
    localparam logic [31:0] PC2 = 32'h0040_0038;
    localparam logic [31:0] PD = 32'h0040_0110; // same index as PA, other tag

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] pcs [6];
        logic [31:0] cur [6];
        logic [31:0] stp [6];
        void'($urandom(32'd4242));
        for (int i = 0; i < 64; i++) begin
            m_tag[i] = '0; m_last[i] = '0; m_stride[i] = '0; m_st[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "reset pf_valid", {31'd0, pf_valid}, 32'd0);

        // R1 allocate, R2 transient, R3 steady
        step("R1", 1, PA, 32'd100, 0, 1);
        step("R2", 1, PA, 32'd103, 0, 1);
        step("R3", 1, PA, 32'd106, 0, 1);
        step("R3", 1, PA, 32'd109, 0, 1);
        // R4 steady mismatch keeps old stride
        step("R4", 1, PA, 32'd200, 0, 1);
        step("R4", 1, PA, 32'd203, 0, 1);
        // R5 irregular sequence
        step("R5", 1, PB, 32'd500, 0, 1);
        step("R5", 1, PB, 32'd510, 0, 1);
        step("R5", 1, PB, 32'd530, 0, 1);
        step("R5", 1, PB, 32'd545, 0, 1);
        step("R5", 1, PB, 32'd560, 0, 1);
        // R6 last line follows every hit (mismatch paths included)
        step("R6", 1, PB, 32'd900, 0, 1);
        step("R6", 1, PB, 32'd915, 0, 1);
        // R7 zero stride
        step("R7", 1, PC2, 32'd700, 0, 1);
        step("R7", 1, PC2, 32'd700, 0, 1);
        step("R7", 1, PC2, 32'd700, 0, 1);
        // R8 line present suppresses
        step("R8", 1, PA, 32'd206, 1, 1);
        step("R8", 1, PA, 32'd209, 0, 1);
        // R9 hold and replacement
        step("R9", 1, PA, 32'd212, 0, 0);
        step("R9", 0, PA, 32'd0,   0, 0);
        step("R9", 0, PA, 32'd0,   0, 0);
        step("R9", 1, PA, 32'd215, 0, 0);
        step("R9", 0, PA, 32'd0,   0, 1);
        // R10 idle cycles
        step("R10", 0, PA, 32'd999, 0, 1);
        step("R10", 1, PA, 32'd218, 0, 1);
        // R11 conflict eviction
        step("R11", 1, PD, 32'd50, 0, 1);
        step("R11", 1, PA, 32'd221, 0, 1);
        step("R11", 1, PA, 32'd224, 0, 1);
        step("R11", 1, PB, 32'd930, 0, 1);

        // random mix
        pcs[0] = PA; pcs[1] = PB; pcs[2] = PC2; pcs[3] = PD;
        pcs[4] = 32'h0040_00FC; pcs[5] = 32'h0041_0040;
        for (int i = 0; i < 6; i++) begin
            cur[i] = 32'd10000 * (i + 1);
            stp[i] = 32'($urandom_range(0, 8)) - 32'd3;
        end
        for (int n = 0; n < 3000; n++) begin
            int k = int'($urandom_range(0, 5));
            bit v = ($urandom_range(0, 7) != 0);
            if (v) begin
                if ($urandom_range(0, 9) == 0) cur[k] = cur[k] + 32'($urandom_range(0, 40));
                else cur[k] = cur[k] + stp[k];
            end
            step("R9", v, pcs[k], cur[k], ($urandom_range(0, 4) == 0), ($urandom_range(0, 3) != 0));
        end
        step("R10", 0, PA, 32'd0, 0, 1);
        @(negedge clk);
        chk("R10", "final pf_valid", {31'd0, pf_valid}, {31'd0, mv});

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule